// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block resolves a virtual page number into a physical page number by probing a hashed page table held in physical memory. It accepts a lookup made of a virtual page number and a process identifier. It folds the two into a slot number and adds that slot's offset to a table base address. It then reads the entries of the slot one at a time and compares each stored page number and process identifier with the request.

When nothing in the first slot matches, a second slot picked by an alternate hash is scanned in the same way. The block reports one of three outcomes: a hit carrying the physical page number, a page fault carrying the stored disk page number of a non-resident page, or a miss. A miss tells software to resolve the translation through its full page table.

The hashing, slot probes and entry scan all run in hardware over a plain request/response memory read port, one entry per transaction. The table is built and maintained elsewhere; this block only reads it.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: The first slot number is h1 = ((vpn[19:10] XOR vpn[9:0]) + pid) mod 16. Entry `w` (0..7) of slot `s` is read at word address `tbl_base + s*8 + w`.
- R3: Entries of a slot are read in order 0 to 7, one memory transaction each. A raised `mem_req_valid` keeps the same `mem_req_addr` until `mem_req_ready` accepts it, and no lookup issues more than 16 reads.
- R4: The entry word layout is: valid at bit 49, resident at bit 48, page number at bits 47:28, process identifier at bits 27:20, stored page number at bits 19:0. An entry matches only if valid is 1 and both tags equal the request. Invalid entries and entries with another process identifier are skipped.
- R5: The scan ends at the first matching entry, and later entries are not read.
- R6: If none of the 8 first-slot entries matches, slot h2 = (NOT h1) mod 16 is scanned in the same way.
- R7: A matching entry with resident = 1 yields `res_kind` = 1 (hit) and `res_ppn` = its stored page number.
- R8: A matching entry with resident = 0 yields `res_kind` = 2 (page fault) and `res_ppn` = its stored disk page number.
- R9: When all 16 entries fail to match, the result is `res_kind` = 3 (miss) with `res_ppn` = 0.
- R10: `res_valid` is a one-cycle pulse that rises one clock after the memory response that decides the lookup, and `req_ready` is 1 in the following cycle.
- R11: A request presented while a lookup is in flight is ignored and does not change that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | 32 | Word address of the table start, captured with the request |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_vpn | input | 20 | Virtual page number to translate |
| req_pid | input | 8 | Process identifier of the request |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Word address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 50 | Entry word returned by memory |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 1 hit, 2 page fault, 3 miss |
| res_ppn | output | 20 | Physical or disk page number, 0 on a miss |

## Verification
Each entry costs at least two cycles: one to issue the read and one to take the response. The memory model in the bench adds random acceptance stalls and zero to two cycles of response delay, so the bench never waits a fixed count for a result. It polls `res_valid` on falling edges and records the cycle of the last response it delivered. It then checks that the pulse came exactly one cycle later and that `req_ready` is back the cycle after that. The order of read addresses and the number of reads for each lookup are compared with a bench model of the scan.

// File: rtl/hpt_pkg.sv
// Shared types of the hashed page table lookup engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hpt_pkg;
    // Outcome code of one lookup as seen on res_kind.
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2,
        RES_MISS  = 2'd3
    } res_kind_e;
endpackage

// File: rtl/hpt_hash.sv
// Slot hash unit: folds a page number and a process identifier into the
// primary slot number, and derives the alternate slot by complementing it.
// Assumes VPN_W is even and SLOT_BITS is not wider than the folded sum.
module hpt_hash #(
    parameter int VPN_W     = 20,
    parameter int PID_W     = 8,
    parameter int SLOT_BITS = 4
) (
    input  logic [VPN_W-1:0]     vpn,
    input  logic [PID_W-1:0]     pid,
    output logic [SLOT_BITS-1:0] slot_pri,
    output logic [SLOT_BITS-1:0] slot_alt
);
    localparam int HALF  = VPN_W / 2;
    localparam int SUM_W = ((HALF > PID_W) ? HALF : PID_W) + 1;

    logic [HALF-1:0]  folded;
    logic [SUM_W-1:0] sum;

    // Fold the page number and add the process identifier.
    always_comb begin
        folded   = vpn[VPN_W-1:HALF] ^ vpn[HALF-1:0];
        sum      = SUM_W'(folded) + SUM_W'(pid);
        slot_pri = sum[SLOT_BITS-1:0];
        slot_alt = ~sum[SLOT_BITS-1:0];
    end
endmodule

// File: rtl/hpt_entry_cmp.sv
// Entry decoder: splits one table word into its fields and reports whether
// it is a valid entry tagged with the requested page number and process.
// Layout (MSB first): valid, resident, vpn, pid, stored page number.
module hpt_entry_cmp #(
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PPN_W = 20
) (
    input  logic [VPN_W+PID_W+PPN_W+1:0] entry,
    input  logic [VPN_W-1:0]             vpn,
    input  logic [PID_W-1:0]             pid,
    output logic                         match,
    output logic                         resident,
    output logic [PPN_W-1:0]             page_num
);
    localparam int PID_LO = PPN_W;
    localparam int VPN_LO = PPN_W + PID_W;
    localparam int RES_B  = VPN_LO + VPN_W;
    localparam int VAL_B  = RES_B + 1;

    logic             e_valid;
    logic [VPN_W-1:0] e_vpn;
    logic [PID_W-1:0] e_pid;

    // Field extraction and tag comparison.
    always_comb begin
        e_valid  = entry[VAL_B];
        resident = entry[RES_B];
        e_vpn    = entry[VPN_LO +: VPN_W];
        e_pid    = entry[PID_LO +: PID_W];
        page_num = entry[PPN_W-1:0];
        match    = e_valid && (e_vpn == vpn) && (e_pid == pid);
    end
endmodule

// File: rtl/hpt_ctrl.sv
// Scan sequencer: walks the entries of the primary slot, then those of the
// alternate slot, one memory read at a time, and records the outcome.
// Assumes the memory returns exactly one response per accepted read.
module hpt_ctrl
    import hpt_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int PPN_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    output logic                    capture,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    input  logic                    mem_rsp_valid,
    input  logic                    ent_match,
    input  logic                    ent_resident,
    input  logic [PPN_W-1:0]        ent_num,
    output logic                    slot_sel,
    output logic [$clog2(WAYS)-1:0] way_idx,
    output logic                    res_valid,
    output res_kind_e               res_kind,
    output logic [PPN_W-1:0]        res_ppn
);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;
    state_e state;

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (state == S_IDLE);
        capture       = (state == S_IDLE) && req_valid;
        mem_req_valid = (state == S_ISSUE);
        res_valid     = (state == S_RESP);
    end

    // Scan state, position and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            slot_sel <= 1'b0;
            way_idx  <= '0;
            res_kind <= RES_NONE;
            res_ppn  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        state    <= S_ISSUE;
                        slot_sel <= 1'b0;
                        way_idx  <= '0;
                    end
                end
                S_ISSUE: begin
                    if (mem_req_ready) begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ent_match) begin
                            res_kind <= ent_resident ? RES_HIT : RES_FAULT;
                            res_ppn  <= ent_num;
                            state    <= S_RESP;
                        end else if (way_idx == LAST_WAY) begin
                            if (!slot_sel) begin
                                slot_sel <= 1'b1;
                                way_idx  <= '0;
                                state    <= S_ISSUE;
                            end else begin
                                res_kind <= RES_MISS;
                                res_ppn  <= '0;
                                state    <= S_RESP;
                            end
                        end else begin
                            way_idx <= way_idx + 1'b1;
                            state   <= S_ISSUE;
                        end
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/hpt_walker.sv
// Hashed page table lookup engine, top level. Captures a request, hashes
// it to two candidate slots, forms entry word addresses from the table base
// and returns hit, page fault or miss. Memory is word addressed, one entry
// per word; the table base is sampled when the request is taken.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int PID_W     = 8,
    parameter int PPN_W     = 20,
    parameter int PA_W      = 32,
    parameter int SLOT_BITS = 4,
    parameter int WAYS      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PA_W-1:0]              tbl_base,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VPN_W-1:0]             req_vpn,
    input  logic [PID_W-1:0]             req_pid,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [PA_W-1:0]              mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [VPN_W+PID_W+PPN_W+1:0] mem_rsp_data,
    output logic                         res_valid,
    output logic [1:0]                   res_kind,
    output logic [PPN_W-1:0]             res_ppn
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OFF_W = SLOT_BITS + WAY_W;

    logic [VPN_W-1:0]     vpn_q;
    logic [PID_W-1:0]     pid_q;
    logic [PA_W-1:0]      base_q;
    logic                 capture;
    logic [SLOT_BITS-1:0] slot_pri, slot_alt, slot_cur;
    logic                 slot_sel;
    logic [WAY_W-1:0]     way_idx;
    logic                 ent_match, ent_resident;
    logic [PPN_W-1:0]     ent_num;
    res_kind_e            kind_q;
    logic [OFF_W-1:0]     entry_off;

    // Request capture while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            pid_q  <= '0;
            base_q <= '0;
        end else if (capture) begin
            vpn_q  <= req_vpn;
            pid_q  <= req_pid;
            base_q <= tbl_base;
        end
    end

    hpt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .SLOT_BITS(SLOT_BITS)) u_hash (
        .vpn      (vpn_q),
        .pid      (pid_q),
        .slot_pri (slot_pri),
        .slot_alt (slot_alt)
    );

    hpt_entry_cmp #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_cmp (
        .entry    (mem_rsp_data),
        .vpn      (vpn_q),
        .pid      (pid_q),
        .match    (ent_match),
        .resident (ent_resident),
        .page_num (ent_num)
    );

    hpt_ctrl #(.WAYS(WAYS), .PPN_W(PPN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .capture       (capture),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_match     (ent_match),
        .ent_resident  (ent_resident),
        .ent_num       (ent_num),
        .slot_sel      (slot_sel),
        .way_idx       (way_idx),
        .res_valid     (res_valid),
        .res_kind      (kind_q),
        .res_ppn       (res_ppn)
    );

    // Entry address: base plus slot-major, way-minor word offset.
    always_comb begin
        slot_cur     = slot_sel ? slot_alt : slot_pri;
        entry_off    = {slot_cur, way_idx};
        mem_req_addr = base_q + PA_W'(entry_off);
        res_kind     = kind_q;
    end
endmodule

// File: rtl/hpt_walker_chk.sv
// Protocol checker for hpt_walker, attached by bind. Counts reads accepted
// during each lookup and checks handshake and result pulse rules.
module hpt_walker_chk #(
    parameter int PA_W = 32,
    parameter int WAYS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            res_valid,
    input logic [1:0]      res_kind
);
    localparam int MAX_RD = 2 * WAYS;
    int unsigned rd_cnt;

    // Reads accepted since the last result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0;
        end else if (res_valid) begin
            rd_cnt <= 0;
        end else if (mem_req_valid && mem_req_ready) begin
            rd_cnt <= rd_cnt + 1;
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (rd_cnt >= 1 && rd_cnt <= MAX_RD));

    // R9
    miss_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd3) |-> (rd_cnt == MAX_RD));

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (mem_req_valid || res_valid)));

    // R7
    kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_kind != 2'd0));
endmodule

bind hpt_walker hpt_walker_chk #(.PA_W(PA_W), .WAYS(WAYS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_kind      (res_kind)
);

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
// Bench for hpt_walker: memory model with random stalls and delays,
// directed corner cases, then seeded random lookups against a scan model.
module tb_hpt_walker;
    localparam int EW = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   tbl_base = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [19:0]   req_vpn = '0;
    logic [7:0]    req_pid = '0;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [31:0]   mem_req_addr;
    logic          mem_rsp_valid;
    logic [EW-1:0] mem_rsp_data;
    logic          res_valid;
    logic [1:0]    res_kind;
    logic [19:0]   res_ppn;

    hpt_walker dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_pid(req_pid),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_kind(res_kind), .res_ppn(res_ppn)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [EW-1:0] mem [512];
    int unsigned cyc = 0;
    int unsigned last_rsp = 0;
    int unsigned nreads = 0;
    logic [31:0] addr_log [32];
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int unsigned dly = 0;

    // Expected outcome of the current lookup.
    logic [1:0]  exp_kind;
    logic [19:0] exp_ppn;
    int unsigned exp_n;
    logic [31:0] exp_addr [16];

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: random acceptance, 0..2 cycles extra response delay.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            pend          <= 1'b0;
            nreads        <= 0;
        end else begin
            mem_req_ready <= ($urandom_range(3) != 0);
            mem_rsp_valid <= 1'b0;
            if (mem_rsp_valid) last_rsp <= cyc;
            if (req_valid && req_ready) nreads <= 0;
            if (mem_req_valid && mem_req_ready) begin
                pend      <= 1'b1;
                pend_addr <= mem_req_addr;
                dly       <= $urandom_range(2);
                if (nreads < 32) addr_log[nreads] <= mem_req_addr;
                nreads    <= nreads + 1;
            end else if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[pend_addr[8:0]];
                    pend          <= 1'b0;
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    function automatic logic [EW-1:0] mk(input bit v, input bit r, input logic [19:0] vp,
                                          input logic [7:0] pd, input logic [19:0] pp);
        return {v, r, vp, pd, pp};
    endfunction

    function automatic int unsigned hash1(input logic [19:0] vp, input logic [7:0] pd);
        return ((int'(vp[19:10] ^ vp[9:0]) + int'(pd)) & 15);
    endfunction

    // Reference scan over the bench memory (R2, R4, R5, R6).
    task automatic model(input logic [19:0] vp, input logic [7:0] pd, input logic [31:0] base);
        int unsigned h1 = hash1(vp, pd);
        exp_kind = 2'd3;
        exp_ppn  = '0;
        exp_n    = 0;
        for (int s = 0; s < 2; s++) begin
            int unsigned slot = (s == 0) ? h1 : ((~h1) & 15);
            for (int w = 0; w < 8; w++) begin
                logic [31:0] a = base + slot * 8 + w;
                logic [EW-1:0] e = mem[a[8:0]];
                exp_addr[exp_n] = a;
                exp_n++;
                if (e[49] && e[47:28] == vp && e[27:20] == pd) begin
                    exp_kind = e[48] ? 2'd1 : 2'd2;
                    exp_ppn  = e[19:0];
                    return;
                end
            end
        end
    endtask

    task automatic lookup(input logic [19:0] vp, input logic [7:0] pd, input logic [31:0] base,
                          input string tag, input bit noise);
        int unsigned t = 0;
        bit addr_ok = 1'b1;
        int unsigned lat;
        model(vp, pd, base);
        @(negedge clk);
        req_vpn = vp; req_pid = pd; tbl_base = base; req_valid = 1'b1;
        @(negedge clk);
        if (noise) begin
            req_vpn = vp ^ 20'h1; req_pid = pd ^ 8'h1; tbl_base = base ^ 32'h80;
        end else begin
            req_valid = 1'b0;
        end
        while (!res_valid && t < 1000) begin
            @(negedge clk);
            t++;
        end
        lat = cyc - last_rsp;
        req_valid = 1'b0;
        chk(res_valid, tag, "result arrived", res_valid, 1);
        chk(res_kind == exp_kind, tag, "kind", res_kind, exp_kind);
        chk(res_ppn == exp_ppn, tag, "page number", res_ppn, exp_ppn);
        chk(nreads == exp_n, "R3/R5", "read count", nreads, exp_n);
        for (int i = 0; i < 16; i++)
            if (i < exp_n && i < nreads && addr_log[i] != exp_addr[i]) addr_ok = 1'b0;
        chk(addr_ok, "R2/R6", "read address order", addr_ok, 1);
        chk(lat == 1, "R10", "result delay after response", lat, 1);
        @(negedge clk);
        chk(!res_valid && req_ready, "R10", "pulse ends and ready returns",
            {res_valid, req_ready}, 2'b01);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = '0;
    endtask

    initial begin
        logic [19:0] pool [8];
        int unsigned h;
        int unsigned seed = $urandom(32'd4711);
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !mem_req_valid && !res_valid, "R1", "outputs in reset",
            {req_ready, mem_req_valid, res_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !res_valid, "R1", "outputs after reset",
            {req_ready, mem_req_valid, res_valid}, 3'b100);

        // R7: hit at entry 0 of the first slot
        h = hash1(20'hABCDE, 8'h05);
        mem[h*8 + 0] = mk(1, 1, 20'hABCDE, 8'h05, 20'h12345);
        lookup(20'hABCDE, 8'h05, 32'd0, "R7", 0);

        // R4: invalid and other-process entries skipped, hit at entry 7
        clear_mem();
        h = hash1(20'h0F0F0, 8'h22);
        for (int w = 0; w < 6; w++) mem[128 + h*8 + w] = mk(0, 1, 20'h0F0F0, 8'h22, 20'h1);
        mem[128 + h*8 + 6] = mk(1, 1, 20'h0F0F0, 8'h23, 20'h2);
        mem[128 + h*8 + 7] = mk(1, 1, 20'h0F0F0, 8'h22, 20'hBEEF0);
        lookup(20'h0F0F0, 8'h22, 32'd128, "R4", 0);

        // R6: only the alternate slot holds the entry
        clear_mem();
        h = hash1(20'h13579, 8'h01);
        mem[256 + ((~h) & 15)*8 + 3] = mk(1, 1, 20'h13579, 8'h01, 20'h0AAAA);
        lookup(20'h13579, 8'h01, 32'd256, "R6", 0);

        // R8: non-resident match reports a page fault
        clear_mem();
        h = hash1(20'h55555, 8'h10);
        mem[h*8 + 2] = mk(1, 0, 20'h55555, 8'h10, 20'hD15C0);
        lookup(20'h55555, 8'h10, 32'd0, "R8", 0);

        // R5: two matches, the earlier one wins
        clear_mem();
        h = hash1(20'h24680, 8'h7F);
        mem[384 + h*8 + 1] = mk(1, 1, 20'h24680, 8'h7F, 20'h11111);
        mem[384 + h*8 + 4] = mk(1, 0, 20'h24680, 8'h7F, 20'h22222);
        lookup(20'h24680, 8'h7F, 32'd384, "R5", 0);

        // R9: nothing matches in either slot
        clear_mem();
        lookup(20'hFFFFF, 8'hFF, 32'd0, "R9", 0);

        // R11: a second request held during the lookup is ignored
        clear_mem();
        h = hash1(20'h3C3C3, 8'h44);
        mem[128 + h*8 + 5] = mk(1, 1, 20'h3C3C3, 8'h44, 20'h77777);
        lookup(20'h3C3C3, 8'h44, 32'd128, "R11", 1);

        // Seeded random lookups over a small tag pool to force collisions.
        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 512; i++)
                mem[i] = mk($urandom_range(1), $urandom_range(1), pool[$urandom_range(7)],
                            8'($urandom_range(1)), 20'($urandom));
            lookup(pool[$urandom_range(7)], 8'($urandom_range(1)),
                   32'($urandom_range(3) * 128), "R7/R8/R9", 0);
        end
        finish_run();
    end
endmodule